// File: doc/BRIEF.md
# Mailbox and Doorbell Console Bridge

This block carries a byte-wide console channel between a host bus master and a local processor. Each direction has its own 32-bit mailbox and its own doorbell register. A mailbox that reads zero is empty. Every character that is sent is stored with bit 31 set, so a mailbox that holds a character is never zero. After loading a mailbox, the sender rings the doorbell toward the receiver with a message code: 1 alive, 2 connect, 3 disconnect, 5 console data.

The host reaches the registers through a simple write strobe and a combinational read port. On the local side there is no register traffic. A receive engine serves the doorbell toward the local side by itself and acknowledges it in the same cycle that it acts on it. It answers alive pings and tracks the connection state. It moves each received character into a circular buffer. Back-pressure comes from withholding the mailbox clear while that buffer is nearly full. A transmit feeder takes characters from a valid/ready stream, loads them into the local-to-host mailbox, rings code 5, and inserts a carriage return after every line feed.

Host register addresses: 0 host-to-local mailbox, 1 local-to-host mailbox, 2 doorbell toward local, 3 doorbell toward host, 4 interrupt enable (bit 0). Any other address reads zero.

Top module: `mbx_console_bridge`

## Requirements
- R1: After reset, all five registers read zero, host_irq_o, rx_valid_o, rx_full_o and conn_o are low, and tx_ready_o is high.
- R2: A host write to address 0 is ignored while that mailbox is nonzero. A write made while it reads zero loads the written value.
- R3: An accepted transmit character c is stored at address 1 as 0x80000000 | c, and the value 5 is ORed into address 3. tx_ready_o stays low while address 1 is nonzero. Any host write to address 1 sets it to zero.
- R4: After a line feed (0x0A) is accepted, tx_ready_o stays low. Once address 1 is emptied again, a carriage return (0x0D) is loaded on its own, with its own code 5.
- R5: A write to address 2 ORs its data into that register. A host write to address 3 clears the bits that are set in the data, and the bits the local side raises are ORed in.
- R6: host_irq_o is high exactly while address 4 bit 0 is set and address 3 is nonzero.
- R7: Whenever address 2 is nonzero, the engine clears it one cycle later. For code 1, it ORs the value 1 into address 3.
- R8: Code 2 raises conn_o. Code 3 lowers it.
- R9: Code 5 with bit 31 of address 0 set appends bits 7:0 to the buffer, in arrival order. If the occupancy including the new character is below DEPTH-4 (252 by default), address 0 is cleared in the same cycle.
- R10: If the new occupancy is DEPTH-4 or more, address 0 keeps its value and rx_full_o rises. While rx_full_o is high, code 5 stores nothing.
- R11: When pops bring the occupancy below DEPTH-4 while rx_full_o is high, address 0 is cleared and rx_full_o falls, one cycle after the occupancy drops.
- R12: rx_valid_o is high while the buffer holds a character, and rx_char_o shows the oldest one. A pop on an empty buffer has no effect.
- R13: Code 5 with bit 31 of address 0 clear stores nothing and clears address 0. Any unknown code is acknowledged and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 3 | Host register address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational) |
| host_irq_o | output | 1 | Interrupt toward the host |
| tx_valid_i | input | 1 | Local transmit character valid |
| tx_char_i | input | 8 | Local transmit character |
| tx_ready_o | output | 1 | Transmit character accepted this cycle |
| rx_pop_i | input | 1 | Remove the oldest received character |
| rx_char_o | output | 8 | Oldest received character |
| rx_valid_o | output | 1 | Receive buffer not empty |
| rx_full_o | output | 1 | Back-pressure active, mailbox clear withheld |
| conn_o | output | 1 | Host connection state |

## Verification
The bench fills the buffer to the exact threshold. A design with an off-by-one in the threshold would either clear the mailbox on the 252nd character or withhold the clear one character early. While the buffer is held full, the bench re-rings code 5. A design that stored the character again would surface a 253rd pop. The bench also drains one character and expects the delayed clear; a design that missed it would leave the host blocked forever. The other targets are these: the line-feed/carriage-return pairing, where a design that dropped the CR would leave address 1 empty after the clear; the write guard on a nonzero mailbox, where a design that overwrote it would lose the first character; the partial clear and OR merge on address 3; and a pop on an empty buffer, which would corrupt the read pointer if it were honoured.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    RA_H2L_MBX   = 3'd0,
    RA_L2H_MBX   = 3'd1,
    RA_DB_TO_LOC = 3'd2,
    RA_DB_TO_HST = 3'd3,
    RA_IRQ_EN    = 3'd4
  } reg_addr_e;

  localparam logic [WORD_W-1:0] MSG_ALIVE   = 32'd1;
  localparam logic [WORD_W-1:0] MSG_CONNECT = 32'd2;
  localparam logic [WORD_W-1:0] MSG_DISCONN = 32'd3;
  localparam logic [WORD_W-1:0] MSG_DATA    = 32'd5;

  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_CR = 8'h0D;
endpackage

// File: rtl/mbx_rx_ring.sv
module mbx_rx_ring #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [7:0]    push_char_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output logic [7:0]    head_o,
  output logic          valid_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_char_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + PW'(1);
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o = cnt_q;
  assign head_o  = mem_q[rd_q];
  assign valid_o = (cnt_q != '0);

  a_r12_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r12_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !valid_o) |=> !valid_o);
endmodule

// File: rtl/mbx_rx_engine.sv
module mbx_rx_engine
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned MARGIN = 4,
  parameter int unsigned CW     = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] db_i,
  input  logic              mbx_flag_i,
  input  logic [CW-1:0]     count_i,
  output logic              push_o,
  output logic              ack_o,
  output logic              clr_mbx_o,
  output logic              alive_o,
  output logic              conn_o,
  output logic              full_o
);
  localparam int unsigned TH = DEPTH - MARGIN;

  logic          conn_q, full_q;
  logic          conn_set, conn_clr, full_set, full_clr;
  logic [CW:0]   occ_next;

  assign occ_next = {1'b0, count_i} + (CW+1)'(1);

  always_comb begin
    push_o    = 1'b0;
    ack_o     = (db_i != '0);
    clr_mbx_o = 1'b0;
    alive_o   = 1'b0;
    conn_set  = 1'b0;
    conn_clr  = 1'b0;
    full_set  = 1'b0;
    full_clr  = 1'b0;
    // drain below threshold releases the held mailbox
    if (full_q && (count_i < CW'(TH))) begin
      clr_mbx_o = 1'b1;
      full_clr  = 1'b1;
    end
    if (db_i != '0) begin
      case (db_i)
        MSG_ALIVE:   alive_o  = 1'b1;
        MSG_CONNECT: conn_set = 1'b1;
        MSG_DISCONN: conn_clr = 1'b1;
        MSG_DATA: begin
          if (!full_q) begin
            if (mbx_flag_i) begin
              push_o = 1'b1;
              if (occ_next < (CW+1)'(TH)) clr_mbx_o = 1'b1;
              else                         full_set  = 1'b1;
            end else begin
              clr_mbx_o = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (conn_set)      conn_q <= 1'b1;
      else if (conn_clr) conn_q <= 1'b0;
      if (full_set)      full_q <= 1'b1;
      else if (full_clr) full_q <= 1'b0;
    end
  end

  assign conn_o = conn_q;
  assign full_o = full_q;

  a_r10_full_at_threshold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> (count_i >= CW'(TH)));
  a_r10_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> !push_o);
endmodule

// File: rtl/mbx_tx_feeder.sv
module mbx_tx_feeder
  import mbx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_char_i,
  input  logic       mbx_empty_i,
  output logic       tx_ready_o,
  output logic       load_o,
  output logic [7:0] load_char_o
);
  logic cr_pend_q;
  logic take;

  assign tx_ready_o  = mbx_empty_i && !cr_pend_q;
  assign take        = tx_valid_i && tx_ready_o;
  assign load_o      = take || (cr_pend_q && mbx_empty_i);
  assign load_char_o = cr_pend_q ? CH_CR : tx_char_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cr_pend_q <= 1'b0;
    else if (take && tx_char_i == CH_LF)  cr_pend_q <= 1'b1;
    else if (cr_pend_q && mbx_empty_i)    cr_pend_q <= 1'b0;
  end

  a_r3_load_into_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> mbx_empty_i);
  a_r4_lf_blocks_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && tx_char_i == CH_LF) |=> !tx_ready_o);
endmodule

// File: rtl/mbx_console_bridge.sv
module mbx_console_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned MARGIN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [2:0]        host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              host_irq_o,
  input  logic              tx_valid_i,
  input  logic [7:0]        tx_char_i,
  output logic              tx_ready_o,
  input  logic              rx_pop_i,
  output logic [7:0]        rx_char_o,
  output logic              rx_valid_o,
  output logic              rx_full_o,
  output logic              conn_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [WORD_W-1:0] mbx_h2l_q, mbx_l2h_q, db_loc_q, db_hst_q;
  logic              irq_en_q;
  logic              wr_h2l, wr_l2h, wr_dbl, wr_dbh, wr_ien;
  logic              push, ack, clr_mbx, alive, load;
  logic [7:0]        load_char;
  logic [CW-1:0]     count;

  assign wr_h2l = host_we_i && host_addr_i == RA_H2L_MBX;
  assign wr_l2h = host_we_i && host_addr_i == RA_L2H_MBX;
  assign wr_dbl = host_we_i && host_addr_i == RA_DB_TO_LOC;
  assign wr_dbh = host_we_i && host_addr_i == RA_DB_TO_HST;
  assign wr_ien = host_we_i && host_addr_i == RA_IRQ_EN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbx_h2l_q <= '0;
      mbx_l2h_q <= '0;
      db_loc_q  <= '0;
      db_hst_q  <= '0;
      irq_en_q  <= 1'b0;
    end else begin
      if (clr_mbx)                          mbx_h2l_q <= '0;
      else if (wr_h2l && mbx_h2l_q == '0)   mbx_h2l_q <= host_wdata_i;
      if (load)        mbx_l2h_q <= {1'b1, 23'd0, load_char};
      else if (wr_l2h) mbx_l2h_q <= '0;
      db_loc_q <= (ack ? '0 : db_loc_q) | (wr_dbl ? host_wdata_i : '0);
      db_hst_q <= (db_hst_q & ~(wr_dbh ? host_wdata_i : '0))
                | (alive ? MSG_ALIVE : '0) | (load ? MSG_DATA : '0);
      if (wr_ien) irq_en_q <= host_wdata_i[0];
    end
  end

  always_comb begin
    case (host_addr_i)
      RA_H2L_MBX:   host_rdata_o = mbx_h2l_q;
      RA_L2H_MBX:   host_rdata_o = mbx_l2h_q;
      RA_DB_TO_LOC: host_rdata_o = db_loc_q;
      RA_DB_TO_HST: host_rdata_o = db_hst_q;
      RA_IRQ_EN:    host_rdata_o = {31'd0, irq_en_q};
      default:      host_rdata_o = '0;
    endcase
  end

  assign host_irq_o = irq_en_q && (db_hst_q != '0);

  mbx_rx_engine #(.DEPTH(DEPTH), .MARGIN(MARGIN), .CW(CW)) u_engine (
    .clk_i, .rst_ni,
    .db_i       (db_loc_q),
    .mbx_flag_i (mbx_h2l_q[31]),
    .count_i    (count),
    .push_o     (push),
    .ack_o      (ack),
    .clr_mbx_o  (clr_mbx),
    .alive_o    (alive),
    .conn_o     (conn_o),
    .full_o     (rx_full_o)
  );

  mbx_rx_ring #(.DEPTH(DEPTH), .CW(CW)) u_ring (
    .clk_i, .rst_ni,
    .push_i      (push),
    .push_char_i (mbx_h2l_q[7:0]),
    .pop_i       (rx_pop_i),
    .count_o     (count),
    .head_o      (rx_char_o),
    .valid_o     (rx_valid_o)
  );

  mbx_tx_feeder u_tx (
    .clk_i, .rst_ni,
    .tx_valid_i, .tx_char_i,
    .mbx_empty_i (mbx_l2h_q == '0),
    .tx_ready_o,
    .load_o      (load),
    .load_char_o (load_char)
  );

  a_r2_mbx_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbx_h2l_q != '0 && !clr_mbx) |=> $stable(mbx_h2l_q));
  a_r3_full_has_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbx_l2h_q != '0) |-> mbx_l2h_q[31]);
  a_r7_doorbell_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_loc_q != '0 && !wr_dbl) |=> (db_loc_q == '0));
endmodule

// File: tb/mbx_console_bridge_test.sv
`timescale 1ns/1ps
module mbx_console_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_char = '0;
  logic        tx_ready;
  logic        rx_pop = 1'b0;
  logic [7:0]  rx_char;
  logic        rx_valid, rx_full, conn;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  mbx_console_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .host_irq_o(host_irq),
    .tx_valid_i(tx_valid), .tx_char_i(tx_char), .tx_ready_o(tx_ready),
    .rx_pop_i(rx_pop), .rx_char_o(rx_char), .rx_valid_o(rx_valid),
    .rx_full_o(rx_full), .conn_o(conn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    tx_valid = 1'b1; tx_char = c;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    chk({tag, " valid"}, 32'(rx_valid), 32'd1);
    chk({tag, " char"}, 32'(rx_char), 32'(exp));
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) chk_reg("R1 reg", 3'(a), 32'd0);
    chk("R1 irq", 32'(host_irq), 32'd0);
    chk("R1 rx_valid", 32'(rx_valid), 32'd0);
    chk("R1 rx_full", 32'(rx_full), 32'd0);
    chk("R1 conn", 32'(conn), 32'd0);
    chk("R1 tx_ready", 32'(tx_ready), 32'd1);
  endtask

  task automatic t_connect;
    wr(3'd2, 32'd2); wait_n(2);
    chk("R8 connect", 32'(conn), 32'd1);
    chk_reg("R7 ack after connect", 3'd2, 32'd0);
    wr(3'd2, 32'd3); wait_n(2);
    chk("R8 disconnect", 32'(conn), 32'd0);
  endtask

  task automatic t_alive_irq;
    wr(3'd2, 32'd1); wait_n(2);
    chk_reg("R7 alive reply", 3'd3, 32'd1);
    chk_reg("R7 alive acked", 3'd2, 32'd0);
    chk("R6 irq masked", 32'(host_irq), 32'd0);
    wr(3'd4, 32'd1); wait_n(1);
    chk("R6 irq enabled", 32'(host_irq), 32'd1);
    wr(3'd3, 32'hFFFF_FFFF); wait_n(1);
    chk_reg("R5 w1c all", 3'd3, 32'd0);
    chk("R6 irq cleared", 32'(host_irq), 32'd0);
  endtask

  task automatic t_tx;
    send(8'h41);
    chk_reg("R3 mailbox", 3'd1, 32'h8000_0041);
    chk_reg("R3 doorbell", 3'd3, 32'd5);
    chk("R3 ready low", 32'(tx_ready), 32'd0);
    chk("R6 irq on data", 32'(host_irq), 32'd1);
    wr(3'd3, 32'd1); wait_n(1);
    chk_reg("R5 partial w1c", 3'd3, 32'd4);
    wr(3'd2, 32'd1); wait_n(2);
    chk_reg("R5 or merge", 3'd3, 32'd5);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, 32'd0); wait_n(1);
    chk_reg("R3 host clear", 3'd1, 32'd0);
    chk("R3 ready back", 32'(tx_ready), 32'd1);
  endtask

  task automatic t_newline;
    send(8'h0A);
    chk_reg("R4 lf stored", 3'd1, 32'h8000_000A);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, 32'd0);
    chk("R4 ready held for cr", 32'(tx_ready), 32'd0);
    wait_n(2);
    chk_reg("R4 cr stored", 3'd1, 32'h8000_000D);
    chk_reg("R4 cr doorbell", 3'd3, 32'd5);
    wr(3'd1, 32'd0); wait_n(1);
    chk("R4 ready after cr", 32'(tx_ready), 32'd1);
    chk_reg("R4 no extra char", 3'd1, 32'd0);
    wr(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_guard;
    wr(3'd0, 32'h8000_0055);
    chk_reg("R2 first write", 3'd0, 32'h8000_0055);
    wr(3'd0, 32'h8000_0066);
    chk_reg("R2 write ignored", 3'd0, 32'h8000_0055);
    wr(3'd2, 32'd5); wait_n(2);
    chk_reg("R9 mailbox cleared", 3'd0, 32'd0);
    pop_chk("R9 stored char", 8'h55);
    wait_n(1);
    chk("R12 empty after pop", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_discard;
    wr(3'd0, 32'h0000_0077);
    wr(3'd2, 32'd5); wait_n(2);
    chk_reg("R13 flagless cleared", 3'd0, 32'd0);
    chk("R13 flagless not stored", 32'(rx_valid), 32'd0);
    wr(3'd2, 32'd7); wait_n(2);
    chk_reg("R13 unknown acked", 3'd2, 32'd0);
    chk_reg("R13 unknown no reply", 3'd3, 32'd0);
    chk("R13 unknown conn", 32'(conn), 32'd0);
    chk("R13 unknown no push", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_empty_pop;
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    chk("R12 pop empty", 32'(rx_valid), 32'd0);
    wr(3'd0, 32'h8000_0033);
    wr(3'd2, 32'd5); wait_n(2);
    pop_chk("R12 pointer intact", 8'h33);
    wait_n(1);
    chk("R12 empty again", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_fill_drain;
    logic [31:0] v;
    for (int i = 0; i < 252; i++) begin
      wr(3'd0, 32'h8000_0000 | 32'(i));
      wr(3'd2, 32'd5); wait_n(2);
      rd(3'd0, v);
      if (i < 251) chk("R9 clear below threshold", v, 32'd0);
      else         chk("R10 held at threshold", v, 32'h8000_00FB);
    end
    chk("R10 full flag", 32'(rx_full), 32'd1);
    wr(3'd2, 32'd5); wait_n(2);
    chk_reg("R10 still held", 3'd0, 32'h8000_00FB);
    pop_chk("R9 order first", 8'h00);
    wait_n(2);
    chk_reg("R11 released", 3'd0, 32'd0);
    chk("R11 full dropped", 32'(rx_full), 32'd0);
    for (int i = 1; i < 252; i++) pop_chk("R9 order", 8'(i));
    wait_n(1);
    chk("R10 no duplicate while full", 32'(rx_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_connect();
    t_alive_irq();
    t_tx();
    t_newline();
    t_guard();
    t_discard();
    t_empty_pop();
    t_fill_drain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule